// File: doc/BRIEF.md
# Sound Register Access Pacer

The pacer stands between a host processor bus and the register file of a sound synthesizer with two register banks: a frequency-modulation (FM) bank and a wavetable/mix (PCM) bank. Every register access takes two steps. The host first writes a register number to an address port. It then writes or reads the value through a data port. After each address write, the synthesizer needs a recovery time before the data step may follow. This time is counted in master clocks and depends on the bank: 56 for FM and 88 for PCM/mix. At the nominal 33.8688 MHz master clock these come to about 1.65 µs and 2.60 µs.

The pacer runs on the master clock. It decodes the bank from the port the host uses and restarts a down-counter on every address write. A data access that arrives too early is held with a wait signal, not lost. A status byte reports which recovery is in progress. Polling software can read it at any time without being stalled. The two status flags respond only after an extended mode bit has been set through an FM register write; with the bit clear, both flags read as zero. As an example of bank addressing, per-channel PCM frequency registers sit at 0x20 plus the channel number.

Top module: `sound_reg_pacer`

## Requirements
- R1: `busPort` selects the port: 0 is the FM address port, 2 is the PCM address port, and 1 or 3 is the data port. A data access always goes to the bank and register number latched at the most recent address write (`regBank` 0 = FM, 1 = PCM), whichever data port carries it.
- R2: After an FM address write in cycle c, a data access is held in cycles c+1 through c+FM_WAIT-1 and is granted in cycle c+FM_WAIT (FM_WAIT = 56).
- R3: After a PCM address write in cycle c, a data access is held in cycles c+1 through c+PCM_WAIT-1 and is granted in cycle c+PCM_WAIT (PCM_WAIT = 88).
- R4: A data access during recovery keeps `busWait` high and raises neither `regWrEn` nor `regRdEn`. In the first cycle with no recovery left, the access completes in that same cycle: `busWait` is low, the matching strobe is high, `regWrData` follows `busWrData`, and a read returns `regRdData` on `busRdData`.
- R5: An address write made while a recovery is running restarts the count with the length of the newly addressed bank.
- R6: A read on either address port (0 or 2) returns the status byte and never raises `busWait`. A read result is driven onto `busRdData` in the same cycle; `busRdData` is 0 when no read completes.
- R7: Status bit 0 (BUSY) is 1 while an FM recovery runs. Status bit 1 (LD) is 1 while a PCM recovery runs. Bits 7..2 are 0.
- R8: The extended mode bit takes bit 0 of any data write to FM register 0x05. While the bit is 0, the status byte reads 0.
- R9: After reset, no recovery is running, the mode bit is 0, `busWait` is low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Host write request, held until granted |
| busRd | input | 1 | Host read request, held until granted |
| busPort | input | 2 | Port select (see R1) |
| busWrData | input | 8 | Host write data (register number or value) |
| busRdData | output | 8 | Host read data: status or register value |
| busWait | output | 1 | Stall for an early data access |
| regWrEn | output | 1 | Register-file write strobe |
| regRdEn | output | 1 | Register-file read strobe |
| regBank | output | 1 | Latched bank, 0 FM, 1 PCM |
| regAddr | output | 8 | Latched register number |
| regWrData | output | 8 | Write value to the register file |
| regRdData | input | 8 | Read value from the register file |

## Verification
The bench measures the exact stall length after address writes to each bank, both when the data access follows at once and when it comes after a status poll. A counter loaded one cycle off would make these lengths 55/57 or 87/89. It also switches banks in the middle of a recovery in both directions. A design that kept the old length or the old bank would release the access early or late, or would strobe the wrong bank. Status reads are made during each kind of recovery, with the mode bit both set and cleared. A flag that ignored the mode gate, or that reported the wrong bank, would mismatch the reference model on that cycle. Data accesses through port 3 after an FM address write check that the bank comes from the latched address and not from the data port number.

// File: rtl/sound_reg_pacer_pkg.sv
package sound_reg_pacer_pkg;

  typedef enum logic {
    BANK_FM  = 1'b0,
    BANK_PCM = 1'b1
  } bank_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  loadAddr;
    bank_e addrBank;
    logic  grantWr;
    logic  grantRd;
    logic  statusRd;
  } pacer_strobes_t;

endpackage

// File: rtl/sound_reg_pacer_ctrl.sv
module sound_reg_pacer_ctrl
  import sound_reg_pacer_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWr,
  input  logic           busRd,
  input  logic [1:0]     busPort,
  input  logic           recovDone,
  output pacer_strobes_t strobes,
  output logic           busWait,
  output logic           regWrEn,
  output logic           regRdEn
);

  logic isDataPort;
  logic dataReq;

  assign isDataPort = busPort[0];
  assign dataReq    = (busWr || busRd) && isDataPort;

  always_comb begin
    strobes          = '0;
    strobes.loadAddr = busWr && !isDataPort;
    strobes.addrBank = busPort[1] ? BANK_PCM : BANK_FM;
    strobes.grantWr  = busWr && isDataPort && recovDone;
    strobes.grantRd  = busRd && isDataPort && recovDone;
    strobes.statusRd = busRd && !isDataPort;
  end

  assign busWait = dataReq && !recovDone;
  assign regWrEn = strobes.grantWr;
  assign regRdEn = strobes.grantRd;

  AST_STATUS_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busPort[0]) |-> !busWait); // R6

endmodule

// File: rtl/sound_reg_pacer_dp.sv
module sound_reg_pacer_dp
  import sound_reg_pacer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FM_WAIT  = 56,
  parameter int PCM_WAIT = 88,
  parameter int MODE_REG = 5,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pacer_strobes_t    strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] busRdData,
  output logic              recovDone,
  output bank_e             bankQ,
  output logic [DATA_W-1:0] addrQ
);

  localparam int MAX_WAIT = (FM_WAIT > PCM_WAIT) ? FM_WAIT : PCM_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT);
  localparam logic [CNT_W-1:0] FM_LOAD  = CNT_W'(FM_WAIT - 1);
  localparam logic [CNT_W-1:0] PCM_LOAD = CNT_W'(PCM_WAIT - 1);

  logic [CNT_W-1:0]  cnt;
  logic              modeQ;
  logic              statusBusy;
  logic              statusLd;
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      addrQ <= '0;
      bankQ <= BANK_FM;
    end else if (strobes.loadAddr) begin
      addrQ <= busWrData;
      bankQ <= strobes.addrBank;
      cnt   <= (strobes.addrBank == BANK_PCM) ? PCM_LOAD : FM_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      modeQ <= 1'b0;
    else if (strobes.grantWr && bankQ == BANK_FM && addrQ == DATA_W'(MODE_REG))
      modeQ <= busWrData[MODE_BIT];
  end

  assign recovDone  = (cnt == '0);
  assign statusBusy = modeQ && !recovDone && bankQ == BANK_FM;
  assign statusLd   = modeQ && !recovDone && bankQ == BANK_PCM;

  always_comb begin
    status    = '0;
    status[0] = statusBusy;
    status[1] = statusLd;
  end

  always_comb begin
    if (strobes.grantRd)       busRdData = regRdData;
    else if (strobes.statusRd) busRdData = status;
    else                       busRdData = '0;
  end

  AST_FM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadAddr && strobes.addrBank == BANK_FM) |=> (cnt == FM_LOAD)); // R2
  AST_PCM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadAddr && strobes.addrBank == BANK_PCM) |=> (cnt == PCM_LOAD)); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadAddr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> (bankQ == $past(strobes.addrBank) && !recovDone)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(statusBusy && statusLd)); // R7
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> (status == '0)); // R8

endmodule

// File: rtl/sound_reg_pacer.sv
module sound_reg_pacer
  import sound_reg_pacer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FM_WAIT  = 56,
  parameter int PCM_WAIT = 88,
  parameter int MODE_REG = 5,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busPort,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busWait,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              regBank,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);

  pacer_strobes_t strobes;
  logic           recovDone;
  bank_e          bankQ;

  sound_reg_pacer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busPort   (busPort),
    .recovDone (recovDone),
    .strobes   (strobes),
    .busWait   (busWait),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn)
  );

  sound_reg_pacer_dp #(
    .DATA_W   (DATA_W),
    .FM_WAIT  (FM_WAIT),
    .PCM_WAIT (PCM_WAIT),
    .MODE_REG (MODE_REG),
    .MODE_BIT (MODE_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .regRdData (regRdData),
    .busRdData (busRdData),
    .recovDone (recovDone),
    .bankQ     (bankQ),
    .addrQ     (regAddr)
  );

  assign regBank   = bankQ;
  assign regWrData = busWrData;

  AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> !busWait); // R4

endmodule

// File: tb/sound_reg_pacer_tb.sv
module sound_reg_pacer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FM_N  = 56;
  localparam int PCM_N = 88;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [1:0] busPort = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       busWait, regWrEn, regRdEn, regBank;
  logic [7:0] regAddr, regWrData, regRdData;

  int vectors = 0;
  int fails   = 0;
  string curReq = "R9";

  // reference model state
  int mRemain = 0;
  int mBank   = 0;
  int mMode   = 0;
  logic [7:0] mAddr = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign regRdData = regAddr ^ 8'h5A;

  sound_reg_pacer u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busPort(busPort),
    .busWrData(busWrData), .busRdData(busRdData), .busWait(busWait),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regBank(regBank), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN) begin
      automatic logic dataReq = (busWr || busRd) && busPort[0];
      automatic logic expWait = dataReq && (mRemain > 0);
      automatic logic expWr   = busWr && busPort[0] && (mRemain == 0);
      automatic logic expRd   = busRd && busPort[0] && (mRemain == 0);
      automatic logic [7:0] expStat = 8'd0;
      automatic logic [7:0] expData;
      if (mMode != 0) begin
        expStat[0] = (mRemain > 0) && (mBank == 0);
        expStat[1] = (mRemain > 0) && (mBank == 1);
      end
      expData = expRd ? (mAddr ^ 8'h5A) : ((busRd && !busPort[0]) ? expStat : 8'd0);
      check(curReq, int'(busWait), int'(expWait), "busWait");
      check(curReq, int'(regWrEn), int'(expWr), "regWrEn");
      check(curReq, int'(regRdEn), int'(expRd), "regRdEn");
      check(curReq, int'(busRdData), int'(expData), "busRdData");
      if (expWr || expRd) begin
        check(curReq, int'(regBank), mBank, "regBank");
        check(curReq, int'(regAddr), int'(mAddr), "regAddr");
        if (expWr) check(curReq, int'(regWrData), int'(busWrData), "regWrData");
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mRemain = 0; mBank = 0; mMode = 0; mAddr = 8'd0;
    end else begin
      automatic logic grantW = busWr && busPort[0] && (mRemain == 0);
      if (grantW && mBank == 0 && mAddr == 8'h05) mMode = int'(busWrData[0]);
      if (busWr && !busPort[0]) begin
        mAddr   = busWrData;
        mBank   = int'(busPort[1]);
        mRemain = busPort[1] ? PCM_N - 1 : FM_N - 1;
      end else if (mRemain > 0) begin
        mRemain--;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic addrWrite(input logic [1:0] port, input logic [7:0] val);
    @(posedge clk); #1;
    busWr = 1'b1; busPort = port; busWrData = val;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  // data access that starts in the cycle right after the caller's last edge + 1
  task automatic dataAccess(input logic isRead, input logic [1:0] port,
                            input logic [7:0] val, output int waited);
    #1;
    busPort = port; busWrData = val;
    if (isRead) busRd = 1'b1; else busWr = 1'b1;
    waited = 0;
    forever begin
      @(negedge clk);
      if (!busWait) break;
      waited++;
    end
    @(posedge clk); #1;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic statusRead(input logic [1:0] port, output logic [7:0] st,
                            output logic stalled);
    #1;
    busPort = port; busRd = 1'b1;
    @(negedge clk);
    st = busRdData; stalled = busWait;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int w;
    logic [7:0] st;
    logic stl;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9: reset state
    curReq = "R9";
    @(negedge clk);
    check("R9", int'(busWait), 0, "busWait after reset");
    @(posedge clk);
    statusRead(2'd0, st, stl);
    check("R9", int'(st), 0, "status after reset");

    // R2 + R8: FM address 0x05, enable mode
    curReq = "R2";
    addrWrite(2'd0, 8'h05);
    dataAccess(1'b0, 2'd1, 8'h01, w);
    check("R2", w, FM_N - 1, "FM wait cycles");

    // R7/R6: status during FM recovery
    curReq = "R7";
    addrWrite(2'd0, 8'h10);
    statusRead(2'd0, st, stl);
    check("R7", int'(st), 1, "BUSY during FM recovery");
    check("R6", int'(stl), 0, "status read stall");
    curReq = "R4";
    dataAccess(1'b1, 2'd1, 8'h00, w);
    check("R4", w, FM_N - 2, "FM wait after one poll");

    // R3: PCM channel 3 frequency register
    curReq = "R3";
    addrWrite(2'd2, 8'h23);
    dataAccess(1'b0, 2'd3, 8'h7C, w);
    check("R3", w, PCM_N - 1, "PCM wait cycles");

    curReq = "R7";
    addrWrite(2'd2, 8'h24);
    statusRead(2'd2, st, stl);
    check("R7", int'(st), 2, "LD during PCM recovery");
    curReq = "R4";
    dataAccess(1'b1, 2'd3, 8'h00, w);
    check("R4", w, PCM_N - 2, "PCM read wait");
    statusRead(2'd0, st, stl);
    check("R7", int'(st), 0, "status idle");

    // R5: FM then PCM mid-recovery, and PCM then FM
    curReq = "R5";
    addrWrite(2'd0, 8'h30);
    idle(10);
    addrWrite(2'd2, 8'h31);
    dataAccess(1'b0, 2'd3, 8'hA5, w);
    check("R5", w, PCM_N - 1, "restart to PCM length");
    addrWrite(2'd2, 8'h32);
    idle(5);
    addrWrite(2'd0, 8'h33);
    dataAccess(1'b0, 2'd1, 8'h3C, w);
    check("R5", w, FM_N - 1, "restart to FM length");

    // R1: port 3 data after FM address goes to FM bank
    curReq = "R1";
    addrWrite(2'd0, 8'h40);
    dataAccess(1'b0, 2'd3, 8'h11, w);
    check("R1", int'(regBank), 0, "bank latched FM");
    addrWrite(2'd2, 8'h41);
    dataAccess(1'b1, 2'd1, 8'h00, w);
    check("R1", int'(regBank), 1, "bank latched PCM");

    // R8: clear mode, flags read zero
    curReq = "R8";
    addrWrite(2'd0, 8'h05);
    dataAccess(1'b0, 2'd1, 8'h00, w);
    addrWrite(2'd2, 8'h20);
    statusRead(2'd0, st, stl);
    check("R8", int'(st), 0, "status with mode off");
    idle(PCM_N + 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule